// File: doc/BRIEF.md
# Three-Write Unlock Gate for Page Writes

This block filters the write stream that feeds a page write sequencer. A write operation is only allowed to store data if it opens with three command writes, in a fixed order, each with a fixed address and data value. The gate absorbs those three command writes. It then forwards the writes that follow as real page loads. Any write that arrives without the full sequence is still forwarded, so that the programming timer and status polling behave normally, but it carries a dummy flag telling the sequencer to store nothing.

The command writes obey the same load window as page loads. Each command write must come within `LOAD_WINDOW` cycles of the one before it, or progress starts over. A write that breaks the sequence is handled as an unprotected write. When a load phase goes quiet for a full window, the gate waits in a programming state until the sequencer reports completion. It then returns to the locked state, so every operation has to present the sequence again. Forwarding is combinational: a write appears on the forward port in the same cycle it is presented.

States:
- `ST_IDLE`: locked, expecting command 0.
- `ST_GOT1`: expecting command 1.
- `ST_GOT2`: expecting command 2.
- `ST_LOAD_REAL`: unlocked, forwarding real loads.
- `ST_LOAD_DUMMY`: forwarding dummy loads.
- `ST_PROG`: waiting for programming to complete.

Transitions:
- A matching write advances `ST_IDLE` to `ST_GOT1`, `ST_GOT1` to `ST_GOT2`, and `ST_GOT2` to `ST_LOAD_REAL`.
- A non-matching write in any of those three states goes to `ST_LOAD_DUMMY`.
- Window expiry in `ST_GOT1` or `ST_GOT2` goes to `ST_IDLE`.
- Window expiry in `ST_LOAD_REAL` goes to `ST_PROG` if any load was taken, otherwise to `ST_IDLE`.
- Window expiry in `ST_LOAD_DUMMY` goes to `ST_PROG`.
- `prog_done` in `ST_PROG` goes to `ST_IDLE`.

Top module: `swp_gate`

## Requirements
- R1: While `rst_n` is low no write is forwarded. Reset returns the gate to the locked start, even in the middle of a sequence.
- R2: The default command pairs are: address 0x1555 with data 0xAA, then 0x0AAA with 0x55, then 0x1555 with 0xA0. Presented in that order, they unlock the gate, and none of the three is forwarded.
- R3: Once unlocked, every write that arrives no more than `LOAD_WINDOW` cycles after the previous write is forwarded with `fwd_dummy` low, carrying its own address and data.
- R4: If more than `LOAD_WINDOW` cycles pass between two command writes, progress returns to the start. The late write is then judged against command 0.
- R5: A write that does not match the next expected command is forwarded with `fwd_dummy` high.
- R6: In a dummy load phase, every later write inside the window is also forwarded as dummy, including writes whose values match a command.
- R7: After `LOAD_WINDOW` idle cycles in a load phase that took at least one load, writes are not forwarded until `prog_done`.
- R8: `prog_done` during programming relocks the gate, so the next write without the sequence is dummy.
- R9: An unlock followed by no load for a whole window relocks without entering programming. The next plain write is forwarded as dummy, not ignored.
- R10: `prog_done` outside the programming state has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | A write event is presented this cycle |
| wr_addr | input | AW | Write address |
| wr_data | input | DW | Write data |
| prog_done | input | 1 | Sequencer finished its programming phase |
| fwd_valid | output | 1 | A write is forwarded to the sequencer this cycle |
| fwd_addr | output | AW | Forwarded address |
| fwd_data | output | DW | Forwarded data |
| fwd_dummy | output | 1 | Forwarded write must start timing but store nothing |

## Verification
The bench builds the gate with 13-bit addresses, 8-bit data, the default command pairs and `LOAD_WINDOW` set to 4. The short window puts every expiry path within a handful of cycles. This makes both a gap of exactly four cycles (accepted) and a gap of five (expired) reachable, for data loads and for command writes alike. With the default pairs, a partial sequence can be broken by a wrong data byte, and a command value can appear inside a dummy phase, which exercises the mismatch and dummy-phase rules.

// File: rtl/swp_pkg.sv
package swp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GOT1,
        ST_GOT2,
        ST_LOAD_REAL,
        ST_LOAD_DUMMY,
        ST_PROG
    } swp_state_e;

    localparam int NUM_CMDS = 3;

endpackage

// File: rtl/swp_cmd_match.sv
module swp_cmd_match #(
    parameter int AW = 13,
    parameter int DW = 8,
    parameter int NCMD = 3,
    parameter logic [NCMD*AW-1:0] CMD_ADDRS = '0,
    parameter logic [NCMD*DW-1:0] CMD_DATAS = '0
) (
    input  logic [AW-1:0]   addr,
    input  logic [DW-1:0]   data,
    output logic [NCMD-1:0] hit
);
    // One comparator per command slot; slot i is packed at bits [i*W +: W].
    for (genvar i = 0; i < NCMD; i++) begin : g_cmp
        assign hit[i] = (addr == CMD_ADDRS[i*AW +: AW]) &&
                        (data == CMD_DATAS[i*DW +: DW]);
    end
endmodule

// File: rtl/swp_window_timer.sv
module swp_window_timer #(
    parameter int WINDOW = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    output logic expired
);
    localparam int CW = $clog2(WINDOW + 1);

    logic [CW-1:0] gap_q;

    // gap_q counts idle cycles since the last write seen while running.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || restart) begin
            gap_q <= '0;
        end else begin
            gap_q <= gap_q + 1'b1;
        end
    end

    assign expired = run && !restart && (gap_q == CW'(WINDOW - 1));
endmodule

// File: rtl/swp_gate.sv
module swp_gate
    import swp_pkg::*;
#(
    parameter int AW = 13,
    parameter int DW = 8,
    parameter int LOAD_WINDOW = 16,
    parameter logic [AW-1:0] CMD0_ADDR = 'h1555,
    parameter logic [DW-1:0] CMD0_DATA = 'hAA,
    parameter logic [AW-1:0] CMD1_ADDR = 'h0AAA,
    parameter logic [DW-1:0] CMD1_DATA = 'h55,
    parameter logic [AW-1:0] CMD2_ADDR = 'h1555,
    parameter logic [DW-1:0] CMD2_DATA = 'hA0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_valid,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          prog_done,
    output logic          fwd_valid,
    output logic [AW-1:0] fwd_addr,
    output logic [DW-1:0] fwd_data,
    output logic          fwd_dummy
);
    localparam logic [NUM_CMDS*AW-1:0] ADDRS = {CMD2_ADDR, CMD1_ADDR, CMD0_ADDR};
    localparam logic [NUM_CMDS*DW-1:0] DATAS = {CMD2_DATA, CMD1_DATA, CMD0_DATA};

    swp_state_e          state_q, state_d;
    logic                loaded_q;
    logic [NUM_CMDS-1:0] hit;
    logic                in_window;
    logic                expired;

    swp_cmd_match #(
        .AW(AW), .DW(DW), .NCMD(NUM_CMDS),
        .CMD_ADDRS(ADDRS), .CMD_DATAS(DATAS)
    ) u_match (
        .addr(wr_addr),
        .data(wr_data),
        .hit (hit)
    );

    assign in_window = (state_q == ST_GOT1) || (state_q == ST_GOT2) ||
                       (state_q == ST_LOAD_REAL) || (state_q == ST_LOAD_DUMMY);

    swp_window_timer #(.WINDOW(LOAD_WINDOW)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (in_window),
        .restart(wr_valid),
        .expired(expired)
    );

    // State register, plus the "a real load was taken" flag of the open phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            loaded_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            loaded_q <= (state_q == ST_LOAD_REAL) && (loaded_q || wr_valid);
        end
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (wr_valid) state_d = hit[0] ? ST_GOT1 : ST_LOAD_DUMMY;
            end
            ST_GOT1: begin
                if (wr_valid)     state_d = hit[1] ? ST_GOT2 : ST_LOAD_DUMMY;
                else if (expired) state_d = ST_IDLE;
            end
            ST_GOT2: begin
                if (wr_valid)     state_d = hit[2] ? ST_LOAD_REAL : ST_LOAD_DUMMY;
                else if (expired) state_d = ST_IDLE;
            end
            ST_LOAD_REAL: begin
                if (!wr_valid && expired) state_d = loaded_q ? ST_PROG : ST_IDLE;
            end
            ST_LOAD_DUMMY: begin
                if (!wr_valid && expired) state_d = ST_PROG;
            end
            ST_PROG: begin
                if (prog_done) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Output logic: forwarding decision for the write presented this cycle.
    always_comb begin
        fwd_valid = 1'b0;
        fwd_dummy = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                fwd_valid = wr_valid && !hit[0];
                fwd_dummy = wr_valid && !hit[0];
            end
            ST_GOT1: begin
                fwd_valid = wr_valid && !hit[1];
                fwd_dummy = wr_valid && !hit[1];
            end
            ST_GOT2: begin
                fwd_valid = wr_valid && !hit[2];
                fwd_dummy = wr_valid && !hit[2];
            end
            ST_LOAD_REAL: begin
                fwd_valid = wr_valid;
            end
            ST_LOAD_DUMMY: begin
                fwd_valid = wr_valid;
                fwd_dummy = wr_valid;
            end
            ST_PROG: begin
                fwd_valid = 1'b0;
            end
            default: begin
                fwd_valid = 1'b0;
            end
        endcase
        if (!rst_n) begin
            fwd_valid = 1'b0;
            fwd_dummy = 1'b0;
        end
    end

    assign fwd_addr = wr_addr;
    assign fwd_data = wr_data;
endmodule

// File: rtl/swp_gate_chk.sv
module swp_gate_chk
    import swp_pkg::*;
#(
    parameter int AW = 13,
    parameter int DW = 8,
    parameter logic [AW-1:0] C0_ADDR = 'h1555,
    parameter logic [DW-1:0] C0_DATA = 'hAA,
    parameter logic [AW-1:0] C2_ADDR = 'h1555,
    parameter logic [DW-1:0] C2_DATA = 'hA0
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_valid,
    input logic [AW-1:0] wr_addr,
    input logic [DW-1:0] wr_data,
    input logic          prog_done,
    input logic          fwd_valid,
    input logic          fwd_dummy,
    input swp_state_e    state
);
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |-> !fwd_valid);

    assert_cmd_hidden_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && wr_valid && wr_addr == C0_ADDR && wr_data == C0_DATA)
        |-> !fwd_valid);

    assert_unlock_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_GOT2 && wr_valid && wr_addr == C2_ADDR && wr_data == C2_DATA)
        |=> (state == ST_LOAD_REAL));

    assert_real_only_unlocked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_valid && !fwd_dummy) |-> (state == ST_LOAD_REAL));

    assert_dummy_is_forward_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_dummy |-> fwd_valid);

    assert_prog_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PROG) |-> !fwd_valid);

    assert_relock_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PROG && prog_done) |=> (state == ST_IDLE));

    assert_done_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && prog_done && !wr_valid) |=> (state == ST_IDLE));
endmodule

bind swp_gate swp_gate_chk #(
    .AW(AW), .DW(DW),
    .C0_ADDR(CMD0_ADDR), .C0_DATA(CMD0_DATA),
    .C2_ADDR(CMD2_ADDR), .C2_DATA(CMD2_DATA)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_valid (wr_valid),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .prog_done(prog_done),
    .fwd_valid(fwd_valid),
    .fwd_dummy(fwd_dummy),
    .state    (state_q)
);

// File: tb/tb_swp_gate.sv
`timescale 1ns/1ps
module tb_swp_gate;
    localparam int AW = 13;
    localparam int DW = 8;
    localparam int WIN = 4;
    localparam int NR = 28;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_valid = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic          prog_done = 1'b0;
    logic          fwd_valid, fwd_dummy;
    logic [AW-1:0] fwd_addr;
    logic [DW-1:0] fwd_data;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    swp_gate #(.AW(AW), .DW(DW), .LOAD_WINDOW(WIN)) dut (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data), .prog_done(prog_done), .fwd_valid(fwd_valid),
        .fwd_addr(fwd_addr), .fwd_data(fwd_data), .fwd_dummy(fwd_dummy)
    );

    // Row: {idle_after[3:0], v, addr[12:0], data[7:0], done, exp_valid, exp_dummy, req[3:0]}
    localparam logic [32:0] TBL [NR] = '{
        {4'd0, 1'b1, 13'h1555, 8'hAA, 1'b0, 1'b0, 1'b0, 4'd2},  // R2 command 0
        {4'd0, 1'b1, 13'h0AAA, 8'h55, 1'b0, 1'b0, 1'b0, 4'd2},  // R2 command 1
        {4'd0, 1'b1, 13'h1555, 8'hA0, 1'b0, 1'b0, 1'b0, 4'd2},  // R2 command 2
        {4'd1, 1'b1, 13'h0040, 8'h11, 1'b0, 1'b1, 1'b0, 4'd3},  // R3 real load
        {4'd4, 1'b1, 13'h0041, 8'h22, 1'b0, 1'b1, 1'b0, 4'd3},  // R3 then window ends
        {4'd0, 1'b1, 13'h0042, 8'h33, 1'b0, 1'b0, 1'b0, 4'd7},  // R7 ignored
        {4'd0, 1'b0, 13'h0000, 8'h00, 1'b1, 1'b0, 1'b0, 4'd8},  // R8 done
        {4'd0, 1'b1, 13'h0050, 8'h44, 1'b0, 1'b1, 1'b1, 4'd8},  // R8 relocked
        {4'd4, 1'b1, 13'h1555, 8'hAA, 1'b0, 1'b1, 1'b1, 4'd6},  // R6 cmd value in dummy
        {4'd0, 1'b0, 13'h0000, 8'h00, 1'b1, 1'b0, 1'b0, 4'd7},
        {4'd0, 1'b1, 13'h1555, 8'hAA, 1'b0, 1'b0, 1'b0, 4'd2},
        {4'd4, 1'b1, 13'h0AAA, 8'h56, 1'b0, 1'b1, 1'b1, 4'd5},  // R5 wrong data
        {4'd0, 1'b1, 13'h0001, 8'h01, 1'b1, 1'b0, 1'b0, 4'd7},  // R7 write in prog
        {4'd4, 1'b1, 13'h1555, 8'hAA, 1'b0, 1'b0, 1'b0, 4'd4},  // R4 then 5-cycle gap
        {4'd4, 1'b1, 13'h0AAA, 8'h55, 1'b0, 1'b1, 1'b1, 4'd4},  // R4 late cmd 1
        {4'd0, 1'b0, 13'h0000, 8'h00, 1'b1, 1'b0, 1'b0, 4'd7},
        {4'd0, 1'b0, 13'h0000, 8'h00, 1'b1, 1'b0, 1'b0, 4'd10}, // R10 stray done
        {4'd0, 1'b1, 13'h1555, 8'hAA, 1'b0, 1'b0, 1'b0, 4'd10},
        {4'd0, 1'b1, 13'h0AAA, 8'h55, 1'b0, 1'b0, 1'b0, 4'd2},
        {4'd4, 1'b1, 13'h1555, 8'hA0, 1'b0, 1'b0, 1'b0, 4'd9},  // R9 no load follows
        {4'd4, 1'b1, 13'h0060, 8'h77, 1'b0, 1'b1, 1'b1, 4'd9},  // R9 dummy not ignored
        {4'd0, 1'b0, 13'h0000, 8'h00, 1'b1, 1'b0, 1'b0, 4'd7},
        {4'd0, 1'b1, 13'h1555, 8'hAA, 1'b0, 1'b0, 1'b0, 4'd2},
        {4'd0, 1'b1, 13'h0AAA, 8'h55, 1'b0, 1'b0, 1'b0, 4'd2},
        {4'd0, 1'b1, 13'h1555, 8'hA0, 1'b0, 1'b0, 1'b0, 4'd2},
        {4'd3, 1'b1, 13'h0070, 8'h01, 1'b0, 1'b1, 1'b0, 4'd3},  // R3 gap exactly WIN
        {4'd4, 1'b1, 13'h0071, 8'h02, 1'b0, 1'b1, 1'b0, 4'd3},
        {4'd0, 1'b0, 13'h0000, 8'h00, 1'b1, 1'b0, 1'b0, 4'd8}
    };

    task automatic chk(input int req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL R%0d %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic cyc(input logic v, input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input logic pd, input logic ev, input logic ed, input int req);
        @(negedge clk);
        wr_valid = v; wr_addr = a; wr_data = d; prog_done = pd;
        #1;
        chk(req, "fwd_valid", int'(fwd_valid), int'(ev));
        chk(req, "fwd_dummy", int'(fwd_dummy), int'(ed));
        if (ev) begin
            chk(req, "fwd_addr", int'(fwd_addr), int'(a));
            chk(req, "fwd_data", int'(fwd_data), int'(d));
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 20000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=expired expected=done");
        summary();
    end

    initial begin
        // R1: reset holds forwarding off even with a plain write present.
        @(negedge clk);
        wr_valid = 1'b1; wr_addr = 13'h0123; wr_data = 8'h9C;
        #1;
        chk(1, "fwd_valid in reset", int'(fwd_valid), 0);
        @(negedge clk);
        wr_valid = 1'b0;
        rst_n = 1'b1;

        for (int i = 0; i < NR; i++) begin
            logic [32:0] r;
            r = TBL[i];
            cyc(r[28], r[27:15], r[14:7], r[6], r[5], r[4], int'(r[3:0]));
            for (int k = 0; k < int'(r[32:29]); k++) begin
                cyc(1'b0, '0, '0, 1'b0, 1'b0, 1'b0, int'(r[3:0]));
            end
        end

        // R1: reset in the middle of a sequence drops progress.
        cyc(1'b1, 13'h1555, 8'hAA, 1'b0, 1'b0, 1'b0, 1);
        cyc(1'b1, 13'h0AAA, 8'h55, 1'b0, 1'b0, 1'b0, 1);
        @(negedge clk);
        wr_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        cyc(1'b1, 13'h1555, 8'hA0, 1'b0, 1'b1, 1'b1, 1);
        for (int k = 0; k < WIN; k++) cyc(1'b0, '0, '0, 1'b0, 1'b0, 1'b0, 7);
        cyc(1'b1, 13'h0002, 8'h02, 1'b0, 1'b0, 1'b0, 7);  // R7 still programming
        cyc(1'b0, '0, '0, 1'b1, 1'b0, 1'b0, 8);
        cyc(1'b1, 13'h0003, 8'h03, 1'b0, 1'b1, 1'b1, 8);  // R8 locked again
        @(negedge clk);
        wr_valid = 1'b0;
        summary();
    end
endmodule